// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

A tag-only cache model driven by a stream of memory references. Each reference gives a byte address and a read/write flag. The controller looks up the indexed set and decides hit or miss. It updates tag, valid and dirty state and applies true least-recently-used replacement. No data is stored. The block only counts the traffic a real cache would cause on its memory side: words fetched, words copied back, misses and replacements.

Two configuration inputs pick the write policy (write-back or write-through) and the allocation policy (write-allocate or write-no-allocate). Both inputs are expected to stay constant between resets. Geometry is set by parameters in bytes: cache size, block size and number of ways. A fully associative cache is the case where the number of ways equals the number of lines, so there is one set. A flush command walks every set and writes back every dirty line. A run of references ends with that flush, and the final copy-back count is valid once the flush completes.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The set index is address bits [OFF_W+IDX_BITS-1:OFF_W] and the tag is the bits above them (defaults: 16-byte blocks and 32 sets, so index bits [8:4] and tag bits [31:9]). A reference hits only when a valid way of that set holds the same tag, so the offset bits never affect the result.
- R2: After reset every line is invalid, all five counters read zero, `req_ready` is 1 and no response is pending.
- R3: Every hit, and every fill, makes the touched way the most recent in its set. On a miss into a full set, the least recent way is the victim. In a two-way set, reading tags A, B, A, C, B gives miss, miss, hit, miss (evicting B), miss (evicting A).
- R4: A fill takes the lowest-numbered invalid way when one exists. It evicts only when every way is valid. `rsp_evict` and `cnt_repl` react only to the eviction of a valid line.
- R5: With write-back (`cfg_write_back`=1), a write marks the line dirty. Evicting a dirty line raises `rsp_evict_dirty` and adds BLOCK_BYTES/4 to `cnt_copyback_words`.
- R6: With write-through (`cfg_write_back`=0), every write adds 1 to `cnt_copyback_words` and no line ever becomes dirty.
- R7: With write-no-allocate (`cfg_write_alloc`=0), a write miss leaves the cache unchanged and adds 1 word to `cnt_copyback_words`. With write-allocate, a write miss fills the line exactly as a read miss does.
- R8: Every accepted reference adds 1 to `cnt_refs`, and every miss adds 1 to `cnt_misses`. Every fill adds BLOCK_BYTES/4 to `cnt_fetch_words`.
- R9: `flush_req` in the idle state starts a flush that takes one cycle per set, with `req_ready` low throughout. Each dirty line adds BLOCK_BYTES/4 to `cnt_copyback_words` and becomes clean, and lines stay valid. A one-cycle `flush_done` pulse follows the last set.
- R10: A reference accepted on a clock edge gives a one-cycle `rsp_valid`, with its hit and eviction flags, right after that edge. The counters are updated on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write_back | input | 1 | 1 = write-back, 0 = write-through |
| cfg_write_alloc | input | 1 | 1 = write-allocate, 0 = write-no-allocate |
| req_valid | input | 1 | Reference offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the reference |
| req_write | input | 1 | 1 = write, 0 = read |
| flush_req | input | 1 | Start a write-back flush of all sets |
| rsp_valid | output | 1 | Response flags valid this cycle |
| rsp_hit | output | 1 | Reference hit |
| rsp_evict | output | 1 | A valid line was replaced |
| rsp_evict_dirty | output | 1 | The replaced line was dirty |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |
| cnt_refs | output | CNT_W | References accepted |
| cnt_misses | output | CNT_W | Misses |
| cnt_repl | output | CNT_W | Valid lines evicted |
| cnt_fetch_words | output | CNT_W | Words fetched from memory |
| cnt_copyback_words | output | CNT_W | Words written to memory |

## Verification
Random references are confined to four sets and six tags, so that hits, fills into free ways, and evictions of clean and dirty lines are all frequent. The stream is run under each of the four write/allocate combinations. A reference model in the bench tracks recency with timestamps rather than age ranks, so any fault in victim choice shows up as different eviction flags or counter values. Directed sequences separate the recency order from the way order (R3), show that a no-allocate write miss leaves the set untouched (R7), and show that lines stay valid but clean after a flush (R9).

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    localparam int unsigned BYTES_PER_WORD = 4;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } ctc_state_e;

    typedef struct packed {
        logic hit;
        logic evict;
        logic evict_dirty;
    } ctc_rsp_t;

    function automatic int unsigned words_in_block(input int unsigned block_bytes);
        return block_bytes / BYTES_PER_WORD;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ctc_addr_split.sv
module ctc_addr_split #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned OFF_W    = 4,
    parameter int unsigned IDX_BITS = 5,
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned TAG_W    = 23
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam logic [ADDR_W-1:0] ONES     = '1;
    localparam logic [ADDR_W-1:0] IDX_MASK = (ONES >> (ADDR_W - IDX_BITS)) << OFF_W;
    localparam int unsigned       TAG_SHIFT = OFF_W + IDX_BITS;

    logic [ADDR_W-1:0] idx_full;
    logic [ADDR_W-1:0] tag_full;

    always_comb begin
        idx_full = (addr & IDX_MASK) >> OFF_W;
        tag_full = addr >> TAG_SHIFT;
        idx      = idx_full[IDX_W-1:0];
        tag      = tag_full[TAG_W-1:0];
    end
endmodule

// File: rtl/ctc_way_select.sv
module ctc_way_select #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TAG_W = 23,
    parameter int unsigned WAY_W = 1
) (
    input  logic [WAYS-1:0]             valid_row,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag_row,
    input  logic [WAYS-1:0][WAY_W-1:0]  age_row,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [WAY_W-1:0]            victim_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAYS-1:0] match;
    logic [WAYS-1:0] oldest;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w]  = valid_row[w] && (tag_row[w] == tag);
        assign oldest[w] = (age_row[w] == OLDEST);
    end

    logic             have_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] lru_way;

    always_comb begin
        hit       = |match;
        hit_way   = '0;
        have_free = 1'b0;
        free_way  = '0;
        lru_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])      hit_way  = WAY_W'(w);
            if (!valid_row[w]) begin
                free_way  = WAY_W'(w);
                have_free = 1'b1;
            end
            if (oldest[w])     lru_way  = WAY_W'(w);
        end
        victim_way = have_free ? free_way : lru_way;
    end
endmodule

// File: rtl/ctc_lru_ages.sv
module ctc_lru_ages #(
    parameter int unsigned SETS  = 32,
    parameter int unsigned WAYS  = 2,
    parameter int unsigned IDX_W = 5,
    parameter int unsigned WAY_W = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0][WAY_W-1:0]  rd_ages,
    input  logic                        touch_en,
    input  logic [WAY_W-1:0]            touch_way
);
    logic [WAYS-1:0][WAY_W-1:0] ages_q [SETS];
    logic [WAY_W-1:0]           touched_age;

    assign rd_ages     = ages_q[rd_idx];
    assign touched_age = rd_ages[touch_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ages_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    ages_q[rd_idx][w] <= '0;
                else if (ages_q[rd_idx][w] < touched_age)
                    ages_q[rd_idx][w] <= ages_q[rd_idx][w] + 1'b1;
            end
        end
    end

    logic [WAYS-1:0] oldest_mask;
    for (genvar w = 0; w < WAYS; w++) begin : g_old
        assign oldest_mask[w] = (rd_ages[w] == WAY_W'(WAYS - 1));
    end

    // ages within a set form a permutation: exactly one way is least recent
    p_lru_unique_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest_mask));
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CACHE_BYTES = 1024,
    parameter int unsigned BLOCK_BYTES = 16,
    parameter int unsigned WAYS        = 2,
    parameter int unsigned CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_write_back,
    input  logic              cfg_write_alloc,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              flush_req,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_evict,
    output logic              rsp_evict_dirty,
    output logic              flush_done,
    output logic [CNT_W-1:0]  cnt_refs,
    output logic [CNT_W-1:0]  cnt_misses,
    output logic [CNT_W-1:0]  cnt_repl,
    output logic [CNT_W-1:0]  cnt_fetch_words,
    output logic [CNT_W-1:0]  cnt_copyback_words
);
    localparam int unsigned LINES    = CACHE_BYTES / BLOCK_BYTES;
    localparam int unsigned SETS     = LINES / WAYS;
    localparam int unsigned OFF_W    = $clog2(BLOCK_BYTES);
    localparam int unsigned IDX_BITS = $clog2(SETS);
    localparam int unsigned IDX_W    = width_of(SETS);
    localparam int unsigned TAG_W    = ADDR_W - OFF_W - IDX_BITS;
    localparam int unsigned WAY_W    = width_of(WAYS);
    localparam logic [CNT_W-1:0] WPB = CNT_W'(words_in_block(BLOCK_BYTES));
    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    // ---------------- state ----------------
    ctc_state_e                  state_q;
    logic [IDX_W-1:0]            fptr_q;
    logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [WAYS-1:0]             valid_q [SETS];
    logic [WAYS-1:0]             dirty_q [SETS];
    ctc_rsp_t                    rsp_q;
    logic                        rsp_valid_q;
    logic                        done_q;
    logic [CNT_W-1:0]            refs_q, miss_q, repl_q, fetch_q, cb_q;

    // ---------------- lookup ----------------
    logic [IDX_W-1:0]            idx;
    logic [TAG_W-1:0]            tag;
    logic [WAYS-1:0][WAY_W-1:0]  age_row;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way, victim_way;

    ctc_addr_split #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_BITS(IDX_BITS),
        .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_split (
        .addr(req_addr), .idx(idx), .tag(tag)
    );

    ctc_way_select #(
        .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_select (
        .valid_row (valid_q[idx]),
        .tag_row   (tag_q[idx]),
        .age_row   (age_row),
        .tag       (tag),
        .hit       (hit),
        .hit_way   (hit_way),
        .victim_way(victim_way)
    );

    // ---------------- decisions ----------------
    logic             fire, alloc, fill, touch, victim_valid, victim_dirty;
    logic             set_dirty_hit, word_write;
    logic [WAY_W-1:0] touch_way;
    logic [CNT_W-1:0] cb_add;
    logic [CNT_W-1:0] flush_dirty_cnt;

    always_comb begin
        fire          = req_valid && req_ready;
        alloc         = !req_write || cfg_write_alloc;
        fill          = fire && !hit && alloc;
        touch         = fire && (hit || alloc);
        touch_way     = hit ? hit_way : victim_way;
        victim_valid  = valid_q[idx][victim_way];
        victim_dirty  = victim_valid && dirty_q[idx][victim_way];
        set_dirty_hit = fire && hit && req_write && cfg_write_back;
        word_write    = fire && req_write && (!cfg_write_back || (!hit && !cfg_write_alloc));
        cb_add        = '0;
        if (fill && victim_dirty) cb_add = cb_add + WPB;
        if (word_write)           cb_add = cb_add + 1'b1;
        flush_dirty_cnt = '0;
        for (int w = 0; w < WAYS; w++)
            if (dirty_q[fptr_q][w]) flush_dirty_cnt = flush_dirty_cnt + WPB;
    end

    ctc_lru_ages #(
        .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_lru (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_ages  (age_row),
        .touch_en (touch),
        .touch_way(touch_way)
    );

    // ---------------- sequential ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            fptr_q      <= '0;
            rsp_q       <= '0;
            rsp_valid_q <= 1'b0;
            done_q      <= 1'b0;
            refs_q      <= '0;
            miss_q      <= '0;
            repl_q      <= '0;
            fetch_q     <= '0;
            cb_q        <= '0;
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]   <= '0;
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            rsp_valid_q <= fire;
            done_q      <= 1'b0;
            if (fire) begin
                rsp_q.hit         <= hit;
                rsp_q.evict       <= fill && victim_valid;
                rsp_q.evict_dirty <= fill && victim_dirty;
                refs_q            <= refs_q + 1'b1;
                if (!hit) miss_q  <= miss_q + 1'b1;
                cb_q              <= cb_q + cb_add;
            end
            if (fill) begin
                fetch_q                  <= fetch_q + WPB;
                tag_q[idx][victim_way]   <= tag;
                valid_q[idx][victim_way] <= 1'b1;
                dirty_q[idx][victim_way] <= req_write && cfg_write_back;
                if (victim_valid) repl_q <= repl_q + 1'b1;
            end
            if (set_dirty_hit)
                dirty_q[idx][hit_way] <= 1'b1;

            case (state_q)
                ST_IDLE: begin
                    if (flush_req) begin
                        state_q <= ST_FLUSH;
                        fptr_q  <= '0;
                    end
                end
                ST_FLUSH: begin
                    cb_q            <= cb_q + flush_dirty_cnt;
                    dirty_q[fptr_q] <= '0;
                    if (fptr_q == LAST_SET) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        fptr_q <= fptr_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready          = (state_q == ST_IDLE);
    assign rsp_valid          = rsp_valid_q;
    assign rsp_hit            = rsp_q.hit;
    assign rsp_evict          = rsp_q.evict;
    assign rsp_evict_dirty    = rsp_q.evict_dirty;
    assign flush_done         = done_q;
    assign cnt_refs           = refs_q;
    assign cnt_misses         = miss_q;
    assign cnt_repl           = repl_q;
    assign cnt_fetch_words    = fetch_q;
    assign cnt_copyback_words = cb_q;

    // ---------------- assertions ----------------
    p_rsp_follows_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    p_refs_step_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cnt_refs == $past(cnt_refs) + 1'b1));

    p_miss_step_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (cnt_misses != '0));

    p_wt_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !cfg_write_back) |-> !rsp_evict_dirty);

    p_evict_on_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_evict) |-> (!rsp_hit && cnt_repl != '0));

    p_flush_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_req && req_ready) |=> !req_ready);

    p_done_ends_flush_r9: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> req_ready);
endmodule

// File: tb/test_cache_tag_ctrl.sv
module test_cache_tag_ctrl;
    localparam int SETS = 32;
    localparam int WAYS = 2;
    localparam int WPB  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_write_back = 1'b1, cfg_write_alloc = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, flush_req = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_hit, rsp_evict, rsp_evict_dirty, flush_done;
    logic [31:0] cnt_refs, cnt_misses, cnt_repl, cnt_fetch_words, cnt_copyback_words;

    always #5 clk = ~clk;

    cache_tag_ctrl i_cache_tag_ctrl (
        .clk(clk), .rst(rst),
        .cfg_write_back(cfg_write_back), .cfg_write_alloc(cfg_write_alloc),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .flush_req(flush_req),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_evict(rsp_evict),
        .rsp_evict_dirty(rsp_evict_dirty), .flush_done(flush_done),
        .cnt_refs(cnt_refs), .cnt_misses(cnt_misses), .cnt_repl(cnt_repl),
        .cnt_fetch_words(cnt_fetch_words), .cnt_copyback_words(cnt_copyback_words)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model: recency by timestamps
    int unsigned m_tag   [SETS][WAYS];
    bit          m_valid [SETS][WAYS];
    bit          m_dirty [SETS][WAYS];
    int unsigned m_stamp [SETS][WAYS];
    int unsigned m_tick;
    int unsigned e_refs, e_miss, e_repl, e_fetch, e_cb;
    bit          e_hit, e_ev, e_evd;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_dirty[s][w] = 0; m_stamp[s][w] = 0; m_tag[s][w] = 0;
            end
        m_tick = 0; e_refs = 0; e_miss = 0; e_repl = 0; e_fetch = 0; e_cb = 0;
    endtask

    function automatic int victim_of(input int s);
        int v = -1;
        for (int w = 0; w < WAYS; w++)
            if (!m_valid[s][w] && v < 0) v = w;
        if (v < 0) begin
            v = 0;
            for (int w = 1; w < WAYS; w++)
                if (m_stamp[s][w] < m_stamp[s][v]) v = w;
        end
        return v;
    endfunction

    task automatic model_step(input logic [31:0] a, input bit wr);
        int s = int'((a >> 4) & 32'h1f);
        int unsigned t = a >> 9;
        int hw = -1;
        bit wb = cfg_write_back, wa = cfg_write_alloc;
        for (int w = 0; w < WAYS; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
        e_hit = (hw >= 0); e_ev = 0; e_evd = 0;
        e_refs++;
        if (!e_hit) e_miss++;
        m_tick++;
        if (e_hit) begin
            m_stamp[s][hw] = m_tick;
            if (wr && wb) m_dirty[s][hw] = 1;
        end else if (!wr || wa) begin
            int v = victim_of(s);
            e_ev  = m_valid[s][v];
            e_evd = e_ev && m_dirty[s][v];
            if (e_ev)  e_repl++;
            if (e_evd) e_cb += WPB;
            e_fetch += WPB;
            m_tag[s][v] = t; m_valid[s][v] = 1; m_dirty[s][v] = wr && wb;
            m_stamp[s][v] = m_tick;
        end
        if (wr && (!wb || (!e_hit && !wa))) e_cb++;
    endtask

    task automatic check_counters(input string req);
        chk(cnt_refs == e_refs, req, "refs", cnt_refs, e_refs);
        chk(cnt_misses == e_miss, req, "misses", cnt_misses, e_miss);
        chk(cnt_repl == e_repl, req, "replacements", cnt_repl, e_repl);
        chk(cnt_fetch_words == e_fetch, req, "fetch words", cnt_fetch_words, e_fetch);
        chk(cnt_copyback_words == e_cb, req, "copyback words", cnt_copyback_words, e_cb);
    endtask

    // called at a negedge; returns at the next negedge with the response checked
    task automatic do_req(input logic [31:0] a, input bit wr, input string req);
        req_valid = 1; req_addr = a; req_write = wr;
        model_step(a, wr);
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 1'b1, "R10", "rsp_valid", rsp_valid, 1);
        chk(rsp_hit == e_hit, req, "hit", rsp_hit, e_hit);
        chk(rsp_evict == e_ev, "R4", "evict", rsp_evict, e_ev);
        chk(rsp_evict_dirty == e_evd, "R5", "evict dirty", rsp_evict_dirty, e_evd);
        check_counters("R8");
    endtask

    function automatic logic [31:0] mk(input int t, input int s, input int off);
        return (32'(t) << 9) | (32'(s) << 4) | 32'(off);
    endfunction

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic do_flush();
        int cyc = 0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (m_dirty[s][w]) begin e_cb += WPB; m_dirty[s][w] = 0; end
        flush_req = 1;
        @(negedge clk);
        flush_req = 0;
        chk(req_ready == 1'b0, "R9", "ready during flush", req_ready, 0);
        while (!flush_done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == SETS, "R9", "flush cycles", cyc, SETS);
        chk(cnt_copyback_words == e_cb, "R9", "copyback after flush", cnt_copyback_words, e_cb);
        @(negedge clk);
        chk(flush_done == 1'b0, "R9", "done pulse width", flush_done, 0);
        chk(req_ready == 1'b1, "R9", "ready after flush", req_ready, 1);
    endtask

    initial begin
        int hits_exp [5] = '{0, 0, 1, 0, 0};
        int ev_exp   [5] = '{0, 0, 0, 1, 1};
        int seq_tag  [5] = '{100, 101, 100, 102, 101};
        void'($urandom(32'd2024));
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
        // R2 reset state
        chk(req_ready == 1'b1, "R2", "ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid", rsp_valid, 0);
        check_counters("R2");

        for (int mode = 0; mode < 4; mode++) begin
            cfg_write_back  = mode[0];
            cfg_write_alloc = mode[1];
            do_reset();

            // R3 directed recency order in set 5
            for (int i = 0; i < 5; i++) begin
                do_req(mk(seq_tag[i], 5, i), 1'b0, "R3");
                chk(rsp_hit == hits_exp[i][0], "R3", "directed hit", rsp_hit, hits_exp[i]);
                chk(rsp_evict == ev_exp[i][0], "R3", "directed evict", rsp_evict, ev_exp[i]);
            end
            // R1 other offset, same line: hit
            do_req(mk(102, 5, 12), 1'b0, "R1");
            chk(rsp_hit == 1'b1, "R1", "offset ignored", rsp_hit, 1);

            // R7 write miss then read
            do_req(mk(200, 7, 0), 1'b1, "R7");
            do_req(mk(200, 7, 4), 1'b0, "R7");
            chk(rsp_hit == cfg_write_alloc, "R7", "read after write miss", rsp_hit, cfg_write_alloc);

            // R5/R6 write then evict
            do_req(mk(300, 9, 0), 1'b0, "R5");
            do_req(mk(300, 9, 0), 1'b1, "R6");
            do_req(mk(301, 9, 0), 1'b0, "R5");
            do_req(mk(302, 9, 0), 1'b0, "R5");
            chk(rsp_evict_dirty == cfg_write_back, "R5", "dirty victim", rsp_evict_dirty, cfg_write_back);

            // constrained random
            for (int n = 0; n < 400; n++) begin
                int t = 16 + int'($urandom_range(0, 5));
                int s = int'($urandom_range(0, 3));
                int o = int'($urandom_range(0, 15));
                bit w = ($urandom_range(0, 9) < 4);
                do_req(mk(t, s, o), w, "R1");
            end

            do_flush();
            // lines survive flush and are clean (R9)
            do_req(mk(102, 5, 0), 1'b0, "R9");
            chk(rsp_hit == 1'b1, "R9", "valid after flush", rsp_hit, 1);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule